// File: doc/BRIEF.md
# Conditional Skip Controller

This block decides whether an 8-bit CPU skips its next instruction, and then times how long that skipped instruction idles. The sequencer presents one skip-test command at a time. The command carries a test opcode and a selector. The block reads the addressed processor flag, the addressed interrupt request flag or a memory bit value. It returns the decision as a registered skip-pending flag.

When an interrupt-request test finds its flag set, the block raises a one-cycle clear strobe in the same cycle it makes the decision. The strobe also carries the selector, so the flag storage outside the block can clear that request flag as part of the same operation.

After a skip is decided, the sequencer supplies the byte-length class of the next instruction and an extended-format marker. The block loads an idle count from them and holds its idle output high for that many cycles. It then drops skip-pending. While skip-pending is high, the block refuses new skip tests.

Top module: `skip_ctrl`

## Requirements
- R1: After reset, skip_pending, idle, idle_cnt and irq_clr are all 0, and test_ready is 1.
- R2: When a test is accepted, op 0 sets skip_pending on the next cycle if flags[test_sel] is 1. Op 1 sets it if flags[test_sel] is 0. A selector at or above NFLAG reads as a flag value of 0.
- R3: When a test is accepted with op 2, skip_pending is set on the next cycle if irqs[test_sel] is 1. In that case, in the acceptance cycle only, irq_clr is 1 and irq_clr_sel equals test_sel.
- R4: When a test is accepted with op 3, skip_pending is set on the next cycle if irqs[test_sel] is 0, and irq_clr stays 0.
- R5: When a test is accepted, op 4 skips if mem_bit is 1, and op 5 always skips. Ops 6 and 7 never skip.
- R6: A len_valid pulse while skip_pending is high and idle is low loads idle_cnt from len_class. len_class encodes the byte count minus one. The loaded values are: 1 byte gives 4; 2 bytes gives 7 with len_ext set and 8 without; 3 bytes gives 10 with len_ext set and 11 without; 4 bytes gives 14.
- R7: For 1-byte and 4-byte lengths, len_ext has no effect on the loaded count.
- R8: Starting the cycle after the load, idle is high for exactly the loaded number of cycles, and idle_cnt decrements once per cycle. skip_pending falls on the same edge that idle falls.
- R9: While skip_pending is high, test_ready is 0. Any test_valid in that time is ignored: it produces no irq_clr strobe and causes no new decision.
- R10: A len_valid pulse while skip_pending is low starts no idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_valid | input | 1 | Skip-test command present |
| test_op | input | 3 | Test opcode (0..7) |
| test_sel | input | SEL_W | Flag or request selector |
| flags | input | NFLAG | Processor flag vector |
| irqs | input | NIRQ | Interrupt request flag vector |
| mem_bit | input | 1 | Selected working-area memory bit |
| test_ready | output | 1 | A test can be accepted this cycle |
| len_valid | input | 1 | Next-instruction length present |
| len_class | input | 2 | Byte count minus one |
| len_ext | input | 1 | Extended-format marker |
| skip_pending | output | 1 | Next instruction is to be skipped |
| irq_clr | output | 1 | One-cycle clear strobe for the selected request flag |
| irq_clr_sel | output | SEL_W | Request flag to clear |
| idle | output | 1 | Skipped instruction is idling |
| idle_cnt | output | CNT_W | Idle cycles remaining |

## Verification
The assertions assume two things about the inputs. First, the flag storage reflects a clear within the same cycle: a strobe is only ever seen against a set request flag. Second, the sequencer sends len_valid only when a skip is pending. Other len_valid pulses have no effect, and the assertions allow them.

The stimulus changes inputs only at falling edges and holds them for one full cycle. It drives exactly one len_valid after each skip decision. It also fires extra test commands and stray length pulses during idle periods and outside them, to exercise the refusal paths.

// File: rtl/skip_ctrl.sv
module skip_ctrl #(
  parameter int NFLAG = 8,
  parameter int NIRQ  = 32,
  parameter int SEL_W = $clog2(NIRQ),
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_valid,
  input  logic [2:0]       test_op,
  input  logic [SEL_W-1:0] test_sel,
  input  logic [NFLAG-1:0] flags,
  input  logic [NIRQ-1:0]  irqs,
  input  logic             mem_bit,
  output logic             test_ready,
  input  logic             len_valid,
  input  logic [1:0]       len_class,
  input  logic             len_ext,
  output logic             skip_pending,
  output logic             irq_clr,
  output logic [SEL_W-1:0] irq_clr_sel,
  output logic             idle,
  output logic [CNT_W-1:0] idle_cnt
);
  localparam int SELN = 1 << SEL_W;
  localparam logic [CNT_W-1:0] C1  = CNT_W'(4);
  localparam logic [CNT_W-1:0] C2X = CNT_W'(7);
  localparam logic [CNT_W-1:0] C2  = CNT_W'(8);
  localparam logic [CNT_W-1:0] C3X = CNT_W'(10);
  localparam logic [CNT_W-1:0] C3  = CNT_W'(11);
  localparam logic [CNT_W-1:0] C4  = CNT_W'(14);

  logic [SELN-1:0] flag_ext, irq_ext;
  logic f_bit, i_bit, hit, accept;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    flag_ext = '0;
    flag_ext[NFLAG-1:0] = flags;
    irq_ext = '0;
    irq_ext[NIRQ-1:0] = irqs;
  end

  assign f_bit = flag_ext[test_sel];
  assign i_bit = irq_ext[test_sel];
  assign test_ready = !skip_pending;
  assign accept = test_valid && test_ready;

  always_comb begin
    case (test_op)
      3'd0:    hit = f_bit;
      3'd1:    hit = !f_bit;
      3'd2:    hit = i_bit;
      3'd3:    hit = !i_bit;
      3'd4:    hit = mem_bit;
      3'd5:    hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

  assign irq_clr = accept && (test_op == 3'd2) && i_bit;
  assign irq_clr_sel = test_sel;

  always_comb begin
    case (len_class)
      2'd0:    load_val = C1;
      2'd1:    load_val = len_ext ? C2X : C2;
      2'd2:    load_val = len_ext ? C3X : C3;
      default: load_val = C4;
    endcase
  end

  assign idle = (idle_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_pending <= 1'b0;
      idle_cnt     <= '0;
    end else if (accept) begin
      skip_pending <= hit;
    end else if (skip_pending) begin
      if (idle) begin
        idle_cnt <= idle_cnt - 1'b1;
        if (idle_cnt == CNT_W'(1)) skip_pending <= 1'b0;
      end else if (len_valid) begin
        idle_cnt <= load_val;
      end
    end
  end
endmodule

module skip_ctrl_chk #(
  parameter int NIRQ  = 32,
  parameter int SEL_W = 5,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_ready,
  input logic [NIRQ-1:0]  irqs,
  input logic             skip_pending,
  input logic             irq_clr,
  input logic [SEL_W-1:0] irq_clr_sel,
  input logic             idle,
  input logic [CNT_W-1:0] idle_cnt
);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pending |-> !test_ready);
  a_r3_clr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_clr);
  a_r3_clr_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> skip_pending);
  a_r3_clr_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> irqs[irq_clr_sel]);
  a_r8_idle_under_pending: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> skip_pending);
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_cnt > CNT_W'(1)) |=> (idle_cnt == $past(idle_cnt) - 1'b1));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_cnt == CNT_W'(1)) |=> (!skip_pending && !idle));
endmodule

bind skip_ctrl skip_ctrl_chk #(.NIRQ(NIRQ), .SEL_W(SEL_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .test_ready(test_ready), .irqs(irqs),
  .skip_pending(skip_pending), .irq_clr(irq_clr), .irq_clr_sel(irq_clr_sel),
  .idle(idle), .idle_cnt(idle_cnt));

// File: tb/test_skip_ctrl.sv
module test_skip_ctrl;
  localparam int NFLAG = 8, NIRQ = 32, SEL_W = 5, CNT_W = 4;
  logic clk = 0, rst_n = 0;
  logic test_valid = 0, mem_bit = 0, len_valid = 0, len_ext = 0;
  logic [2:0] test_op = 0;
  logic [SEL_W-1:0] test_sel = 0;
  logic [NFLAG-1:0] flags = 0;
  logic [NIRQ-1:0] irqs = 0;
  logic [1:0] len_class = 0;
  logic test_ready, skip_pending, irq_clr, idle;
  logic [SEL_W-1:0] irq_clr_sel;
  logic [CNT_W-1:0] idle_cnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  skip_ctrl #(.NFLAG(NFLAG), .NIRQ(NIRQ), .SEL_W(SEL_W), .CNT_W(CNT_W)) i_skip_ctrl (
    .clk, .rst_n, .test_valid, .test_op, .test_sel, .flags, .irqs, .mem_bit,
    .test_ready, .len_valid, .len_class, .len_ext, .skip_pending, .irq_clr,
    .irq_clr_sel, .idle, .idle_cnt);

  function automatic bit exp_skip(input logic [2:0] op, input logic [SEL_W-1:0] sel,
                                  input logic [NFLAG-1:0] f, input logic [NIRQ-1:0] q,
                                  input logic m);
    bit fb = (sel < NFLAG) ? f[sel] : 1'b0;
    case (op)
      0: return fb;
      1: return !fb;
      2: return q[sel];
      3: return !q[sel];
      4: return m;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_len(input logic [1:0] c, input logic x);
    case (c)
      0: return 4;
      1: return x ? 7 : 8;
      2: return x ? 10 : 11;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_test(input logic [2:0] op, input logic [SEL_W-1:0] sel,
                          input logic [1:0] lc, input logic lx, input bit poke);
    bit s;
    int n;
    string rq;
    s = exp_skip(op, sel, flags, irqs, mem_bit);
    rq = (op < 2) ? "R2" : (op == 2) ? "R3" : (op == 3) ? "R4" : "R5";
    test_op = op; test_sel = sel; test_valid = 1;
    #1;
    chk("R3 strobe", irq_clr, (op == 2) && irqs[sel]);
    if (op == 2 && irqs[sel]) chk("R3 sel", irq_clr_sel, sel);
    @(negedge clk);
    test_valid = 0;
    chk(rq, skip_pending, s);
    chk("R3 strobe width", irq_clr, 0);
    if (!s) return;
    len_class = lc; len_ext = lx; len_valid = 1;
    @(negedge clk);
    len_valid = 0;
    chk("R6 load", idle_cnt, exp_len(lc, lx));
    if (lc == 0 || lc == 3) chk("R7 ext ignored", idle_cnt, exp_len(lc, 0));
    n = 0;
    while (idle && n < 40) begin
      chk("R8 count", idle_cnt, exp_len(lc, lx) - n);
      if (poke && n == 1) begin
        chk("R9 ready", test_ready, 0);
        test_op = 2; test_valid = 1; irqs[sel] = 1;
        #1;
        chk("R9 no strobe", irq_clr, 0);
      end
      @(negedge clk);
      test_valid = 0;
      n++;
    end
    chk("R8 idle length", n, exp_len(lc, lx));
    chk("R8 pending cleared", skip_pending, 0);
    if (poke) chk("R9 no new decision", skip_pending, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 pending", skip_pending, 0);
    chk("R1 idle", idle, 0);
    chk("R1 cnt", idle_cnt, 0);
    chk("R1 strobe", irq_clr, 0);
    chk("R1 ready", test_ready, 1);
    rst_n = 1;
    @(negedge clk);
    len_valid = 1; len_class = 3;
    @(negedge clk);
    len_valid = 0;
    chk("R10 stray length", idle, 0);
    flags = 8'h05; irqs = 32'h0000_0010; mem_bit = 1;
    run_test(0, 0, 0, 1, 0);
    run_test(0, 1, 1, 1, 0);
    run_test(1, 1, 1, 0, 0);
    run_test(0, 9, 2, 0, 0);
    run_test(2, 4, 2, 1, 1);
    run_test(2, 5, 0, 0, 0);
    run_test(3, 5, 3, 1, 0);
    run_test(3, 4, 0, 0, 0);
    run_test(4, 0, 3, 0, 0);
    run_test(5, 0, 1, 0, 1);
    run_test(6, 0, 0, 0, 0);
    run_test(7, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      flags = NFLAG'($urandom); irqs = $urandom; mem_bit = 1'($urandom);
      run_test(3'($urandom), SEL_W'($urandom), 2'($urandom), 1'($urandom),
               ($urandom % 4) == 0);
      if (($urandom % 8) == 0) begin
        len_valid = 1; len_class = 2'($urandom);
        @(negedge clk);
        len_valid = 0;
        chk("R10 stray length", idle, 0);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule